// File: doc/BRIEF.md
# DSP Logical ALU with Flags

This unit performs the bitwise logic step of a fixed-point DSP datapath. Each issued operation combines two 40-bit operands, a 32-bit word under an 8-bit guard extension, with AND, OR or XOR. It returns a destination value with a one-cycle write strobe and keeps a five-flag status word (DC, N, Z, V, GT) in its own register.

Only the upper half of the word (bits 31 to 16) passes through the logic. The low half and the guard extension of the result are always zero. Unconditional operations rewrite every flag from the result. Conditional operations never touch the flags: they write the destination only when their condition input is true. The 3-bit condition-select input decides what the DC flag records.

Top module: `dsp_logic_alu`

## Requirements
- R1: With valid_i high and op_i at 00 (AND), 01 (OR) or 10 (XOR), the result of the operation on source bits 31:16 appears on dst_o[31:16] after the next rising clock edge. dst_we_o is high for exactly that cycle.
- R2: In every written result, dst_o[39:32] and dst_o[15:0] are zero, whatever the guard and low bits of the sources are.
- R3: An unconditional operation (cond_i low) rewrites all flags. flags_o bit 1 (N) is result bit 31. Bit 2 (Z) is 1 when result bits 31:16 are all zero. Bit 3 (V) is 0. Bit 4 (GT) is 1 when the result is neither zero nor negative.
- R4: On an unconditional operation with cs_i 000 or 011, flags_o bit 0 (DC) becomes 0.
- R5: On an unconditional operation, cs_i 001 loads DC with result bit 31, and cs_i 010 loads DC with the zero indication.
- R6: On an unconditional operation, cs_i 100 loads DC with GT, cs_i 101 loads DC with the inverse of N, and cs_i 110 or 111 clears DC.
- R7: A conditional operation (cond_i high) with cond_true_i high writes the destination and leaves all flags unchanged.
- R8: A conditional operation with cond_true_i low deasserts dst_we_o and leaves both dst_o and the flags unchanged.
- R9: A cycle with valid_i low, or with op_i at 11, writes nothing and leaves dst_o and the flags unchanged.
- R10: While rst_ni is low, dst_o, dst_we_o and flags_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation issued this cycle |
| op_i | input | 2 | 00 AND, 01 OR, 10 XOR, 11 no operation |
| cond_i | input | 1 | Operation is conditional |
| cond_true_i | input | 1 | Condition outcome for a conditional operation |
| cs_i | input | 3 | Condition-select code for the DC flag |
| src1_i | input | 40 | Source operand 1 (guard 39:32, word 31:0) |
| src2_i | input | 40 | Source operand 2 (guard 39:32, word 31:0) |
| dst_o | output | 40 | Registered destination value |
| dst_we_o | output | 1 | Destination write enable, one cycle per write |
| flags_o | output | 5 | Status flags: bit0 DC, bit1 N, bit2 Z, bit3 V, bit4 GT |

## Verification
The bench builds the block with its default parameters: an 8-bit guard, a 32-bit word and a logic field starting at bit 16. With these values the bench reaches the sign bit at position 31 and the two zeroed fields on either side of the active slice. It can also drive nonzero guard and low source bits that must never reach the result. A reference model in the bench tracks destination and flags every cycle. It walks all eight condition-select codes with negative, zero and positive results, and mixes conditional, false-condition and idle cycles in a long random run.

// File: rtl/dsp_lu_pkg.sv
package dsp_lu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_XOR  = 2'b10,
    OP_NONE = 2'b11
  } lu_op_e;

  typedef enum logic [2:0] {
    CS_CARRY = 3'd0,
    CS_NEG   = 3'd1,
    CS_ZERO  = 3'd2,
    CS_OVF   = 3'd3,
    CS_GT    = 3'd4,
    CS_NNEG  = 3'd5,
    CS_RSV6  = 3'd6,
    CS_RSV7  = 3'd7
  } lu_cs_e;

  // bit0 dc .. bit4 gt
  typedef struct packed {
    logic gt;
    logic v;
    logic z;
    logic n;
    logic dc;
  } lu_flags_t;
endpackage

// File: rtl/dsp_lu_core.sv
module dsp_lu_core
  import dsp_lu_pkg::*;
#(
  parameter int unsigned ACT_W = 16
) (
  input  logic [ACT_W-1:0] a_i,
  input  logic [ACT_W-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [ACT_W-1:0] res_o
);
  for (genvar g = 0; g < ACT_W; g++) begin : g_bit
    always_comb begin
      unique case (op_i)
        OP_AND:  res_o[g] = a_i[g] & b_i[g];
        OP_OR:   res_o[g] = a_i[g] | b_i[g];
        OP_XOR:  res_o[g] = a_i[g] ^ b_i[g];
        default: res_o[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dsp_lu_flags.sv
module dsp_lu_flags
  import dsp_lu_pkg::*;
#(
  parameter int unsigned ACT_W = 16
) (
  input  logic [ACT_W-1:0] res_i,
  input  logic [2:0]       cs_i,
  output lu_flags_t        flags_o
);
  logic zero, neg, pos;

  assign zero = ~|res_i;
  assign neg  = res_i[ACT_W-1];
  assign pos  = ~zero & ~neg;

  always_comb begin
    flags_o.n  = neg;
    flags_o.z  = zero;
    flags_o.v  = 1'b0;
    flags_o.gt = pos;
    unique case (lu_cs_e'(cs_i))
      CS_NEG:  flags_o.dc = neg;
      CS_ZERO: flags_o.dc = zero;
      CS_GT:   flags_o.dc = pos;
      CS_NNEG: flags_o.dc = ~neg;
      default: flags_o.dc = 1'b0; // carry, overflow, reserved
    endcase
  end
endmodule

// File: rtl/dsp_logic_alu.sv
module dsp_logic_alu
  import dsp_lu_pkg::*;
#(
  parameter int unsigned GUARD_W = 8,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ACT_LO  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [1:0]                  op_i,
  input  logic                        cond_i,
  input  logic                        cond_true_i,
  input  logic [2:0]                  cs_i,
  input  logic [GUARD_W+WORD_W-1:0]   src1_i,
  input  logic [GUARD_W+WORD_W-1:0]   src2_i,
  output logic [GUARD_W+WORD_W-1:0]   dst_o,
  output logic                        dst_we_o,
  output logic [4:0]                  flags_o
);
  localparam int unsigned DATA_W = GUARD_W + WORD_W;
  localparam int unsigned ACT_W  = WORD_W - ACT_LO;

  logic [ACT_W-1:0] res;
  lu_flags_t        flags_new, flags_q;
  logic             issue, do_write, do_flags;
  logic [DATA_W-1:0] dst_q;
  logic              we_q;

  // guard and low source bits never reach the logic
  logic unused_src;
  assign unused_src = ^{src1_i[DATA_W-1:WORD_W], src1_i[ACT_LO-1:0],
                        src2_i[DATA_W-1:WORD_W], src2_i[ACT_LO-1:0]};

  dsp_lu_core #(.ACT_W(ACT_W)) u_core (
    .a_i   (src1_i[WORD_W-1:ACT_LO]),
    .b_i   (src2_i[WORD_W-1:ACT_LO]),
    .op_i  (op_i),
    .res_o (res)
  );

  dsp_lu_flags #(.ACT_W(ACT_W)) u_flags (
    .res_i   (res),
    .cs_i    (cs_i),
    .flags_o (flags_new)
  );

  assign issue    = valid_i && (op_i != OP_NONE);
  assign do_write = issue && (!cond_i || cond_true_i);
  assign do_flags = issue && !cond_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q   <= '0;
      we_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      we_q <= do_write;
      if (do_write) dst_q <= {{GUARD_W{1'b0}}, res, {ACT_LO{1'b0}}};
      if (do_flags) flags_q <= flags_new;
    end
  end

  assign dst_o    = dst_q;
  assign dst_we_o = we_q;
  assign flags_o  = flags_q;
endmodule

// File: rtl/dsp_lu_chk.sv
module dsp_lu_chk #(
  parameter int unsigned GUARD_W = 8,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ACT_LO  = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      valid_i,
  input logic [1:0]                op_i,
  input logic                      cond_i,
  input logic                      cond_true_i,
  input logic [GUARD_W+WORD_W-1:0] dst_o,
  input logic                      dst_we_o,
  input logic [4:0]                flags_o
);
  localparam int unsigned DATA_W = GUARD_W + WORD_W;

  a_r1_we_follows_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 2'b11 && (!cond_i || cond_true_i)) |=> dst_we_o);

  a_r2_fields_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_we_o |-> (dst_o[DATA_W-1:WORD_W] == '0 && dst_o[ACT_LO-1:0] == '0));

  a_r3_v_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3] == 1'b0);

  a_r3_n_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 2'b11 && !cond_i) |=> flags_o[1] == dst_o[WORD_W-1]);

  a_r3_gt_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[4] |-> (!flags_o[1] && !flags_o[2]));

  a_r7_cond_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i) |=> $stable(flags_o));

  a_r8_false_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i && !cond_true_i) |=> (!dst_we_o && $stable(dst_o)));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i == 2'b11) |=> (!dst_we_o && $stable(dst_o) && $stable(flags_o)));
endmodule

bind dsp_logic_alu dsp_lu_chk #(
  .GUARD_W(GUARD_W), .WORD_W(WORD_W), .ACT_LO(ACT_LO)
) u_chk (.*);

// File: tb/tb_dsp_logic_alu.sv
module tb_dsp_logic_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        cnd = 1'b0;
  logic        cnd_true = 1'b0;
  logic [2:0]  cs = 3'd0;
  logic [39:0] s1 = '0, s2 = '0;
  logic [39:0] dst;
  logic        we;
  logic [4:0]  flags;

  int n_chk = 0, n_fail = 0;
  logic [39:0] e_dst = '0;
  logic        e_we = 1'b0;
  logic [4:0]  e_flags = '0;
  bit          done = 0;

  always #5 clk = ~clk;

  dsp_logic_alu dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .cond_i(cnd),
    .cond_true_i(cnd_true), .cs_i(cs), .src1_i(s1), .src2_i(s2),
    .dst_o(dst), .dst_we_o(we), .flags_o(flags)
  );

  task automatic check(string tag);
    n_chk++;
    if (dst !== e_dst || we !== e_we || flags !== e_flags) begin
      n_fail++;
      $display("FAIL %s: dst=%h we=%b flags=%b expected dst=%h we=%b flags=%b",
               tag, dst, we, flags, e_dst, e_we, e_flags);
    end
  endtask

  task automatic step(string tag, logic v, logic [1:0] o, logic c, logic ct,
                      logic [2:0] sel, logic [39:0] a, logic [39:0] b);
    logic [15:0] r;
    logic n, z, g, d;
    bit issue, wr;
    valid = v; op = o; cnd = c; cnd_true = ct; cs = sel; s1 = a; s2 = b;
    @(posedge clk);
    #2;
    case (o)
      2'b00: r = a[31:16] & b[31:16];
      2'b01: r = a[31:16] | b[31:16];
      default: r = a[31:16] ^ b[31:16];
    endcase
    issue = v && (o != 2'b11);
    wr = issue && (!c || ct);
    e_we = wr;
    if (wr) e_dst = {8'h00, r, 16'h0000};
    if (issue && !c) begin
      n = r[15]; z = (r == 16'h0); g = !n && !z;
      case (sel)
        3'd1: d = n;
        3'd2: d = z;
        3'd4: d = g;
        3'd5: d = !n;
        default: d = 1'b0;
      endcase
      e_flags = {g, 1'b0, z, n, d};
    end
    check(tag);
  endtask

  initial begin
    #23;
    check("R10 reset");
    @(negedge clk);
    check("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 three operations, R2 guard and low bits dirty
    step("R1 AND", 1, 2'b00, 0, 0, 3'd0, 40'hFF_F0F0_1234, 40'hA5_FF00_ABCD);
    step("R1 OR",  1, 2'b01, 0, 0, 3'd0, 40'h12_0F00_FFFF, 40'h34_00F0_FFFF);
    step("R1 XOR", 1, 2'b10, 0, 0, 3'd0, 40'hFF_AAAA_5555, 40'hFF_5555_5555);
    step("R2 zero fields", 1, 2'b01, 0, 0, 3'd0, 40'hFF_0000_FFFF, 40'hFF_0000_FFFF);
    // R3 result classes
    step("R3 negative", 1, 2'b01, 0, 0, 3'd0, 40'h0_8000_0000, 40'h0);
    step("R3 zero",     1, 2'b00, 0, 0, 3'd0, 40'h0_FFFF_0000, 40'h0);
    step("R3 positive", 1, 2'b10, 0, 0, 3'd0, 40'h0_1234_0000, 40'h0);
    // R4 forced-clear codes
    step("R4 cs000 neg", 1, 2'b01, 0, 0, 3'd0, 40'h0_F000_0000, 40'h0);
    step("R4 cs011 zero", 1, 2'b00, 0, 0, 3'd3, 40'h0, 40'h0);
    step("R4 cs011 neg", 1, 2'b01, 0, 0, 3'd3, 40'h0_8001_0000, 40'h0);
    // R5
    step("R5 cs001 neg", 1, 2'b01, 0, 0, 3'd1, 40'h0_8000_0000, 40'h0);
    step("R5 cs001 pos", 1, 2'b01, 0, 0, 3'd1, 40'h0_0001_0000, 40'h0);
    step("R5 cs010 zero", 1, 2'b10, 0, 0, 3'd2, 40'h0_5A5A_0000, 40'h0_5A5A_0000);
    step("R5 cs010 nonzero", 1, 2'b10, 0, 0, 3'd2, 40'h0_5A5A_0000, 40'h0);
    // R6
    step("R6 cs100 pos", 1, 2'b01, 0, 0, 3'd4, 40'h0_0100_0000, 40'h0);
    step("R6 cs100 zero", 1, 2'b00, 0, 0, 3'd4, 40'h0, 40'h0);
    step("R6 cs101 neg", 1, 2'b01, 0, 0, 3'd5, 40'h0_C000_0000, 40'h0);
    step("R6 cs101 zero", 1, 2'b00, 0, 0, 3'd5, 40'h0, 40'h0);
    step("R6 cs110 zero", 1, 2'b00, 0, 0, 3'd6, 40'h0, 40'h0);
    step("R6 cs111 pos", 1, 2'b01, 0, 0, 3'd7, 40'h0_0010_0000, 40'h0);
    // R7: set known flags, then conditional write with different result class
    step("R7 setup", 1, 2'b00, 0, 0, 3'd2, 40'h0, 40'h0);
    step("R7 cond true", 1, 2'b01, 1, 1, 3'd1, 40'h0_8000_0000, 40'h0);
    // R8
    step("R8 cond false", 1, 2'b10, 1, 0, 3'd1, 40'h0_7777_0000, 40'h0);
    // R9
    step("R9 valid low", 0, 2'b01, 0, 0, 3'd1, 40'h0_1111_0000, 40'h0);
    step("R9 op11", 1, 2'b11, 0, 0, 3'd2, 40'h0_2222_0000, 40'h0);
    for (int i = 0; i < 400; i++) begin
      logic [39:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) a[31:16] = b[31:16];
      step("R1 random mix", ($urandom_range(0, 4) != 0), 2'($urandom), 1'($urandom),
           1'($urandom), 3'($urandom), a, b);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule